// File: doc/BRIEF.md
# Paged Packet Buffer Host Window

This block is the host's byte-wide path into a packet buffer RAM that is split into pages. A 16-bit pointer register names a byte inside a page and picks one of two pages. One is the page the host has chosen, given on `host_page`. The other is the page at the head of the receive queue, given on `rx_head_page`. Four data window offsets then read or write that byte.

The pointer has two addressing modes. In stepping mode, every data access uses the stored offset and then advances it. In fixed mode, the window offset adds a small displacement and the pointer stays as it is. The block drives the address, enable, write strobe and write data of an external RAM, which has one cycle of read latency, and it returns read data to the host.

Host requests use a valid/ready handshake and so do the responses. Each accepted read gives exactly one response, in the cycle after acceptance. The response stays valid and unchanged while `rsp_ready` is low. During that time `req_ready` is low, so no new access is taken and the RAM is not enabled. The RAM must hold its read output while it is not enabled. Writes give no response.

Top module: `pbp_port`

## Requirements
- R1: After reset the pointer is 0x0000, `rsp_valid` is low, `req_ready` is high and `ram_en` is low.
- R2: A write to offset 6 replaces pointer bits 7:0 and keeps bits 15:8. A write to offset 7 replaces bits 15:8 and keeps bits 7:0.
- R3: A read of offset 6 returns pointer bits 7:0. A read of offset 7 returns pointer bits 15:8 ANDed with 0xF7. Bit 11 is still stored and kept.
- R4: A data access (offsets 8 to 11) drives `ram_addr` = {page, byte offset}. The page is `rx_head_page` when pointer bit 15 is 1 and `host_page` when it is 0. The byte offset is 11 bits wide.
- R5: With pointer bit 14 set, a data access uses pointer bits 10:0 as the byte offset, whatever the window offset. Afterwards bits 10:0 increase by one, modulo 2048, and bits 15:11 are unchanged.
- R6: With pointer bit 14 clear, the byte offset is (pointer bits 10:0 + window offset bits 1:0) modulo 2048, and the pointer is unchanged.
- R7: An accepted data write raises `ram_en` and `ram_we` in the same cycle, with `ram_wdata` equal to the written byte.
- R8: An accepted read sets `rsp_valid` in the next cycle. For a data read, `rsp_data` is the RAM byte at the address driven at acceptance.
- R9: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low, and `rsp_valid` and `rsp_data` stay unchanged.
- R10: A write to an offset outside 6 to 11 changes neither the pointer nor the RAM. A read of such an offset returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host access request |
| req_ready | output | 1 | Block can take a request |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_offs | input | 4 | Byte offset in the register window |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read response present |
| rsp_ready | input | 1 | Host takes the response |
| rsp_data | output | 8 | Read response byte |
| host_page | input | PAGE_W | Page chosen by the host |
| rx_head_page | input | PAGE_W | Page at the head of the receive queue |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM write strobe |
| ram_addr | output | PAGE_W+OFF_W | RAM byte address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte, one cycle after `ram_en` |

## Verification
A bad pointer value shows up on `ram_addr` in the same cycle as the next data access. It also shows on the read data one cycle later, and in the byte read back from offset 6 or 7. A stepping error therefore appears after a single extra access, and the wrap at the page end is driven on purpose. A wrong page choice gives a wrong page field on the address at once. A wrong stall decision shows as `req_ready` high, or response data that changes, during the first stalled cycle.

// File: rtl/pbp_pkg.sv
package pbp_pkg;

  typedef enum logic [1:0] {
    ACC_OTHER  = 2'd0,
    ACC_PTR_LO = 2'd1,
    ACC_PTR_HI = 2'd2,
    ACC_DATA   = 2'd3
  } acc_e;

  localparam int        PTR_W        = 16;
  localparam int        SEL_RX_BIT   = 15;
  localparam int        AUTO_INC_BIT = 14;
  localparam logic [7:0] HI_RD_MASK  = 8'hF7;

  function automatic acc_e classify(input logic [3:0] offs);
    case (offs)
      4'd6:                     return ACC_PTR_LO;
      4'd7:                     return ACC_PTR_HI;
      4'd8, 4'd9, 4'd10, 4'd11: return ACC_DATA;
      default:                  return ACC_OTHER;
    endcase
  endfunction

endpackage

// File: rtl/pbp_ptr_reg.sv
module pbp_ptr_reg
  import pbp_pkg::*;
#(
  parameter int OFF_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_lo,
  input  logic             wr_hi,
  input  logic [7:0]       wdata,
  input  logic             data_acc,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_q;
  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (wr_lo) begin
      ptr_d[7:0] = wdata;
    end else if (wr_hi) begin
      ptr_d[15:8] = wdata;
    end else if (data_acc && ptr_q[AUTO_INC_BIT]) begin
      ptr_d[OFF_W-1:0] = ptr_q[OFF_W-1:0] + OFF_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R5
  step_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && ptr_q[AUTO_INC_BIT] && !wr_lo && !wr_hi) |=>
      (ptr_q[OFF_W-1:0] == $past(ptr_q[OFF_W-1:0]) + OFF_W'(1)) &&
      (ptr_q[PTR_W-1:OFF_W] == $past(ptr_q[PTR_W-1:OFF_W])));

  // R6
  fixed_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !ptr_q[AUTO_INC_BIT] && !wr_lo && !wr_hi) |=> $stable(ptr_q));

  // R2
  lo_keeps_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo |=> (ptr_q[15:8] == $past(ptr_q[15:8])));

  // R2
  hi_keeps_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_hi && !wr_lo) |=> (ptr_q[7:0] == $past(ptr_q[7:0])));

endmodule

// File: rtl/pbp_addr_gen.sv
module pbp_addr_gen #(
  parameter int PAGE_W = 2,
  parameter int OFF_W  = 11
) (
  input  logic [PAGE_W-1:0]       host_page,
  input  logic [PAGE_W-1:0]       rx_head_page,
  input  logic                    sel_rx,
  input  logic                    auto_inc,
  input  logic [OFF_W-1:0]        ptr_off,
  input  logic [1:0]              win,
  output logic [PAGE_W+OFF_W-1:0] addr
);

  logic [PAGE_W-1:0] page;
  logic [OFF_W-1:0]  byte_off;

  always_comb begin
    page     = sel_rx ? rx_head_page : host_page;
    byte_off = auto_inc ? ptr_off : (ptr_off + OFF_W'(win));
    addr     = {page, byte_off};
  end

endmodule

// File: rtl/pbp_rsp.sv
module pbp_rsp (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ld,
  input  logic       ld_ram,
  input  logic [7:0] ld_byte,
  input  logic       rsp_ready,
  input  logic [7:0] ram_rdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_data
);

  logic       valid_q;
  logic       from_ram_q;
  logic [7:0] byte_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      from_ram_q <= 1'b0;
      byte_q     <= 8'h00;
    end else if (ld) begin
      valid_q    <= 1'b1;
      from_ram_q <= ld_ram;
      byte_q     <= ld_byte;
    end else if (rsp_ready) begin
      valid_q    <= 1'b0;
    end
  end

  assign rsp_valid = valid_q;
  assign rsp_data  = !valid_q ? 8'h00 : (from_ram_q ? ram_rdata : byte_q);

  // R8
  load_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> rsp_valid);

endmodule

// File: rtl/pbp_port.sv
module pbp_port
  import pbp_pkg::*;
#(
  parameter int PAGE_W = 2,
  parameter int OFF_W  = 11
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [3:0]              req_offs,
  input  logic [7:0]              req_wdata,
  output logic                    rsp_valid,
  input  logic                    rsp_ready,
  output logic [7:0]              rsp_data,
  input  logic [PAGE_W-1:0]       host_page,
  input  logic [PAGE_W-1:0]       rx_head_page,
  output logic                    ram_en,
  output logic                    ram_we,
  output logic [PAGE_W+OFF_W-1:0] ram_addr,
  output logic [7:0]              ram_wdata,
  input  logic [7:0]              ram_rdata
);

  localparam int ADDR_W = PAGE_W + OFF_W;

  acc_e             kind;
  logic             accept;
  logic             wr_lo;
  logic             wr_hi;
  logic             data_acc;
  logic [PTR_W-1:0] ptr;
  logic [7:0]       reg_byte;
  logic [ADDR_W-1:0] addr;

  assign kind      = classify(req_offs);
  assign req_ready = !(rsp_valid && !rsp_ready);
  assign accept    = req_valid && req_ready;
  assign wr_lo     = accept && req_write && (kind == ACC_PTR_LO);
  assign wr_hi     = accept && req_write && (kind == ACC_PTR_HI);
  assign data_acc  = accept && (kind == ACC_DATA);

  pbp_ptr_reg #(.OFF_W(OFF_W)) ptr_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_lo    (wr_lo),
    .wr_hi    (wr_hi),
    .wdata    (req_wdata),
    .data_acc (data_acc),
    .ptr      (ptr)
  );

  pbp_addr_gen #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) addr_i (
    .host_page    (host_page),
    .rx_head_page (rx_head_page),
    .sel_rx       (ptr[SEL_RX_BIT]),
    .auto_inc     (ptr[AUTO_INC_BIT]),
    .ptr_off      (ptr[OFF_W-1:0]),
    .win          (req_offs[1:0]),
    .addr         (addr)
  );

  always_comb begin
    case (kind)
      ACC_PTR_LO: reg_byte = ptr[7:0];
      ACC_PTR_HI: reg_byte = ptr[15:8] & HI_RD_MASK;
      default:    reg_byte = 8'h00;
    endcase
  end

  pbp_rsp rsp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld        (accept && !req_write),
    .ld_ram    (kind == ACC_DATA),
    .ld_byte   (reg_byte),
    .rsp_ready (rsp_ready),
    .ram_rdata (ram_rdata),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  assign ram_en    = data_acc;
  assign ram_we    = data_acc && req_write;
  assign ram_wdata = req_wdata;
  assign ram_addr  = addr;

  // R9
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R10
  other_offs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (kind == ACC_OTHER)) |=> $stable(ptr));

endmodule

// File: tb/pbp_port_tb_top.sv
`timescale 1ns/100ps
module pbp_port_tb_top;

  localparam int PAGE_W = 2;
  localparam int OFF_W  = 11;
  localparam int AW     = PAGE_W + OFF_W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [3:0]    req_offs = '0;
  logic [7:0]    req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_ready = 1'b1;
  logic [7:0]    rsp_data;
  logic [PAGE_W-1:0] host_page = '0;
  logic [PAGE_W-1:0] rx_head_page = '0;
  logic          ram_en;
  logic          ram_we;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;
  logic [7:0]    ram_rdata = 8'h00;

  int total = 0;
  int bad = 0;
  logic [15:0] mptr = 16'h0000;

  always #2.5 clk = ~clk;

  pbp_port #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_offs(req_offs), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .host_page(host_page), .rx_head_page(rx_head_page),
    .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  function automatic logic [7:0] pat(input logic [AW-1:0] a);
    return a[7:0] ^ {a[12:11], a[10:5]} ^ 8'h5A;
  endfunction

  // RAM model: one-cycle read latency, output held while not enabled
  always_ff @(posedge clk) begin
    if (ram_en && !ram_we) ram_rdata <= pat(ram_addr);
  end

  task automatic chk(input string rq, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // starts and ends just after a falling edge
  task automatic access(input logic wr, input logic [3:0] offs, input logic [7:0] wd,
                        input logic exp_ram, input logic [AW-1:0] ea,
                        input string rq, output logic [7:0] rd);
    req_valid = 1'b1; req_write = wr; req_offs = offs; req_wdata = wd;
    #1;
    chk({rq, " req_ready"}, int'(req_ready), 1);
    chk({rq, " ram_en"}, int'(ram_en), int'(exp_ram));
    if (exp_ram) begin
      chk({rq, " ram_addr"}, int'(ram_addr), int'(ea));
      chk({rq, " ram_we"}, int'(ram_we), int'(wr));
      if (wr) chk({rq, " ram_wdata"}, int'(ram_wdata), int'(wd));
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    rd = rsp_data;
    if (!wr) chk({rq, " rsp_valid"}, int'(rsp_valid), 1);
  endtask

  function automatic logic [AW-1:0] exp_addr(input logic [1:0] win);
    logic [PAGE_W-1:0] pg;
    int off;
    pg  = mptr[15] ? rx_head_page : host_page;
    off = mptr[14] ? int'(mptr) % 2048 : (int'(mptr) % 2048 + int'(win)) % 2048;
    return {pg, 11'(off)};
  endfunction

  task automatic step_model();
    if (mptr[14]) mptr = (mptr & 16'hF800) | ((mptr + 16'd1) & 16'h07FF);
  endtask

  task automatic set_ptr(input logic [15:0] v);
    logic [7:0] d;
    access(1'b1, 4'd6, v[7:0], 1'b0, '0, "R2", d);
    access(1'b1, 4'd7, v[15:8], 1'b0, '0, "R2", d);
    mptr = v;
  endtask

  task automatic check_ptr(input string rq);
    logic [7:0] d;
    access(1'b0, 4'd6, 8'h00, 1'b0, '0, rq, d);
    chk({rq, " ptr lo"}, int'(d), int'(mptr[7:0]));
    access(1'b0, 4'd7, 8'h00, 1'b0, '0, rq, d);
    chk({rq, " ptr hi R3"}, int'(d), int'(mptr[15:8] & 8'hF7));
  endtask

  task automatic data_rd(input logic [1:0] win, input string rq);
    logic [AW-1:0] ea;
    logic [7:0] d;
    ea = exp_addr(win);
    access(1'b0, 4'd8 + {2'b00, win}, 8'h00, 1'b1, ea, rq, d);
    chk({rq, " R8 data"}, int'(d), int'(pat(ea)));
    step_model();
  endtask

  task automatic data_wr(input logic [1:0] win, input logic [7:0] v, input string rq);
    logic [7:0] d;
    access(1'b1, 4'd8 + {2'b00, win}, v, 1'b1, exp_addr(win), rq, d);
    step_model();
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 ram_en", int'(ram_en), 0);
    check_ptr("R1");

    // R2, R3: sweep both pointer bytes
    for (int v = 0; v < 256; v++) begin
      set_ptr({~8'(v), 8'(v)});
      check_ptr("R2 R3 sweep");
      access(1'b1, 4'd6, 8'(v + 1), 1'b0, '0, "R2", d);
      mptr[7:0] = 8'(v + 1);
      access(1'b0, 4'd7, 8'h00, 1'b0, '0, "R2", d);
      chk("R2 hi kept after lo write", int'(d), int'(mptr[15:8] & 8'hF7));
    end

    // R4, R6: fixed mode, page choice and window displacement with wrap
    for (int pg = 0; pg < 4; pg++) begin
      host_page = 2'(pg);
      rx_head_page = 2'(3 - pg);
      for (int sel = 0; sel < 2; sel++) begin
        for (int b = 0; b < 5; b++) begin
          int base;
          base = (b == 0) ? 0 : (b == 1) ? 5 : (b == 2) ? 2046 : (b == 3) ? 2047 : 1024;
          set_ptr(16'((sel << 15) | 16'h0800 | base));
          for (int w = 0; w < 4; w++) data_rd(2'(w), "R4 R6 fixed read");
          check_ptr("R6 ptr unchanged");
        end
      end
    end

    // R5: stepping mode with wrap at page end, both page sources
    host_page = 2'd1;
    rx_head_page = 2'd2;
    set_ptr(16'hF800 | 16'd2044);
    for (int i = 0; i < 8; i++) data_rd(2'(i % 4), "R5 step read");
    check_ptr("R5 after wrap");
    set_ptr(16'h4000 | 16'd2046);
    for (int i = 0; i < 5; i++) data_rd(2'(3 - (i % 4)), "R5 step read host page");
    check_ptr("R5 upper bits kept");

    // R7: writes in both modes
    set_ptr(16'h0000 | 16'd2045);
    for (int w = 0; w < 4; w++) data_wr(2'(w), 8'(8'h30 + w), "R7 fixed write");
    check_ptr("R7 R6 fixed write ptr");
    set_ptr(16'hC7FE);
    for (int i = 0; i < 4; i++) data_wr(2'(i), 8'(8'hC0 + i), "R7 step write");
    check_ptr("R7 R5 step write ptr");

    // R9: response held under back-pressure
    set_ptr(16'h0123);
    rsp_ready = 1'b0;
    begin
      logic [AW-1:0] ea;
      ea = exp_addr(2'd2);
      access(1'b0, 4'd10, 8'h00, 1'b1, ea, "R9 stalled read", d);
      chk("R9 first data", int'(d), int'(pat(ea)));
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk("R9 rsp_valid held", int'(rsp_valid), 1);
        chk("R9 rsp_data held", int'(rsp_data), int'(pat(ea)));
        chk("R9 req_ready low", int'(req_ready), 0);
        chk("R9 ram_en low", int'(ram_en), 0);
      end
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    chk("R9 rsp drops after take", int'(rsp_valid), 0);
    check_ptr("R9 ptr unchanged");

    // R10: other offsets ignored / read as zero
    set_ptr(16'h8A5C);
    for (int o = 0; o < 16; o++) begin
      if (o < 6 || o > 11) begin
        access(1'b1, 4'(o), 8'hA5, 1'b0, '0, "R10 write", d);
        access(1'b0, 4'(o), 8'h00, 1'b0, '0, "R10 read", d);
        chk("R10 read zero", int'(d), 0);
      end
    end
    check_ptr("R10 ptr unchanged");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule